// File: doc/BRIEF.md
# Cache Write Event Counters

This block keeps two free-running event counts for a two-level inclusive data cache. One count tracks stores seen by the first-level data cache. The other tracks every write that lands in the second-level cache. Each cycle the caches raise single-bit strobes for the events they saw. The block sorts those strobes into the two counts and adds the number of strobes that fired. Several second-level sources can fire in the same cycle.

The second-level count is deliberately wider in scope than the first-level one. It counts CPU writes that look up in the second level, whether they hit or miss. It also counts every line that leaves either first-level cache (data or instruction) and moves into the second level, clean or dirty. Writes that bypass the first level while streaming mode is active count there too. A cache-zero-by-address operation is treated as a store by both counts. Snoops arriving from outside the core are never counted.

Software controls the block through an enable input and a synchronous clear. It reads the two counts and their sticky wrap flags directly from output ports.

Top module: `wrev_counters`

## Requirements
- R1: After reset both counts are zero and both wrap flags are low.
- R2: Each cycle in which `l1_st_lookup` is high while counting is enabled adds one to `l1_wr_count`; by itself it leaves `l2_wr_count` unchanged.
- R3: A high `dc_zero_op` adds one to `l1_wr_count` and one to `l2_wr_count` in the same cycle.
- R4: A high `l2_cpu_wr` adds one to `l2_wr_count` whether `l2_wr_hit` is high (hit) or low (miss), and leaves `l1_wr_count` unchanged.
- R5: A high `l1d_evict` adds one to `l2_wr_count` whatever the value of `l1d_evict_dirty` (1 = dirty line, 0 = clean line), and a high `l1i_evict` also adds one to `l2_wr_count`.
- R6: A high `stream_wr` adds one to `l2_wr_count` and leaves `l1_wr_count` unchanged.
- R7: `ext_snoop` has no effect on either count or either wrap flag.
- R8: When several strobes are high in one cycle, each count grows by the number of its sources that are high: up to 2 for the first-level count and up to 5 for the second-level count.
- R9: A high `cnt_clr` zeroes both counts and both wrap flags at the next edge. It wins over any strobe and over `cnt_en`.
- R10: Counts wrap modulo 2^CNT_W. The wrap flag of a count goes high in the cycle its sum passes 2^CNT_W and stays high until clear or reset.
- R11: While `cnt_en` is low and `cnt_clr` is low, both counts and both flags hold their values and every strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable |
| cnt_clr | input | 1 | Synchronous clear of both counts and flags |
| l1_st_lookup | input | 1 | Store looked up in first-level data cache |
| dc_zero_op | input | 1 | Cache-zero-by-address operation |
| l2_cpu_wr | input | 1 | CPU write looked up in second-level cache |
| l2_wr_hit | input | 1 | Hit (1) or miss (0) of that write; not used for counting |
| l1d_evict | input | 1 | Line evicted from first-level data cache into second level |
| l1d_evict_dirty | input | 1 | Evicted data line was dirty; not used for counting |
| l1i_evict | input | 1 | Line evicted from first-level instruction cache into second level |
| stream_wr | input | 1 | Write sent straight to second level in streaming mode |
| ext_snoop | input | 1 | Snoop from outside the core; never counted |
| l1_wr_count | output | CNT_W | First-level write count |
| l2_wr_count | output | CNT_W | Second-level write count |
| l1_wrap | output | 1 | Sticky wrap flag of the first-level count |
| l2_wrap | output | 1 | Sticky wrap flag of the second-level count |

## Verification
Every count and flag is a single register stage. The effect of strobes, enable or clear presented before a rising edge shows up on the outputs right after that edge and not later. The bench drives each cycle's inputs on the falling edge. It updates its reference model for the following rising edge and compares all outputs 1 ns after that edge, so each comparison covers exactly one cycle of stimulus. A second instance with a 6-bit count width runs on the same inputs, which lets the wrap and sticky-flag behaviour appear within a few dozen cycles.

// File: rtl/wrev_pkg.sv
package wrev_pkg;

   // Number of strobes feeding each count
   localparam int unsigned L1_SRC_N = 2;
   localparam int unsigned L2_SRC_N = 5;

   localparam int unsigned L1_INC_W = $clog2(L1_SRC_N + 1);
   localparam int unsigned L2_INC_W = $clog2(L2_SRC_N + 1);

   // Classified strobes of one cycle
   typedef struct packed {
      logic st_lookup;
      logic zero_op;
      logic cpu_wr;
      logic d_evict;
      logic i_evict;
      logic stream_wr;
   } wrev_strobe_t;

endpackage

// File: rtl/wrev_popcnt.sv
module wrev_popcnt #(
   parameter int unsigned N     = 4,
   parameter int unsigned OUT_W = $clog2(N + 1)
) (
   input  logic [N-1:0]     bits,
   output logic [OUT_W-1:0] ones
);

   generate
      if (N < 1) begin : g_bad_n
         $error("wrev_popcnt: N must be at least 1");
      end
      if (OUT_W < $clog2(N + 1)) begin : g_bad_w
         $error("wrev_popcnt: OUT_W too narrow for N");
      end

      if (N == 1) begin : g_single
         assign ones = OUT_W'(bits[0]);
      end else begin : g_multi
         always_comb begin
            ones = '0;
            for (int i = 0; i < int'(N); i++) begin
               ones = ones + OUT_W'(bits[i]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wrev_classify.sv
module wrev_classify
   import wrev_pkg::*;
(
   input  wrev_strobe_t          stb,
   output logic [L1_INC_W-1:0]   l1_inc,
   output logic [L2_INC_W-1:0]   l2_inc
);

   logic [L1_SRC_N-1:0] l1_vec;
   logic [L2_SRC_N-1:0] l2_vec;

   // A zero-by-address operation is a store for both levels
   assign l1_vec = {stb.zero_op, stb.st_lookup};
   assign l2_vec = {stb.zero_op, stb.stream_wr, stb.i_evict, stb.d_evict, stb.cpu_wr};

   wrev_popcnt #(.N(L1_SRC_N), .OUT_W(L1_INC_W)) u_pc_l1 (
      .bits (l1_vec),
      .ones (l1_inc)
   );

   wrev_popcnt #(.N(L2_SRC_N), .OUT_W(L2_INC_W)) u_pc_l2 (
      .bits (l2_vec),
      .ones (l2_inc)
   );

endmodule

// File: rtl/wrev_accum.sv
module wrev_accum #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned INC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] count,
   output logic             wrapped
);

   localparam int unsigned SUM_W = CNT_W + 1;

   generate
      if (INC_W >= CNT_W) begin : g_bad_inc
         $error("wrev_accum: INC_W must be narrower than CNT_W");
      end
   endgenerate

   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, count} + {{(SUM_W - INC_W){1'b0}}, inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         wrapped <= 1'b0;
      end else if (clr) begin
         count   <= '0;
         wrapped <= 1'b0;
      end else if (en) begin
         count <= sum[CNT_W-1:0];
         if (sum[CNT_W]) begin
            wrapped <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wrev_counters.sv
module wrev_counters
   import wrev_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             cnt_clr,
   input  logic             l1_st_lookup,
   input  logic             dc_zero_op,
   input  logic             l2_cpu_wr,
   input  logic             l2_wr_hit,
   input  logic             l1d_evict,
   input  logic             l1d_evict_dirty,
   input  logic             l1i_evict,
   input  logic             stream_wr,
   input  logic             ext_snoop,
   output logic [CNT_W-1:0] l1_wr_count,
   output logic [CNT_W-1:0] l2_wr_count,
   output logic             l1_wrap,
   output logic             l2_wrap
);

   generate
      if (CNT_W < 4 || CNT_W > 64) begin : g_bad_cnt
         $error("wrev_counters: CNT_W must lie in 4..64");
      end
   endgenerate

   wrev_strobe_t          stb;
   logic [L1_INC_W-1:0]   l1_inc;
   logic [L2_INC_W-1:0]   l2_inc;

   // Hit/miss, clean/dirty and outside snoops take no part in counting
   assign stb.st_lookup = l1_st_lookup;
   assign stb.zero_op   = dc_zero_op;
   assign stb.cpu_wr    = l2_cpu_wr;
   assign stb.d_evict   = l1d_evict;
   assign stb.i_evict   = l1i_evict;
   assign stb.stream_wr = stream_wr;

   wrev_classify u_cls (
      .stb    (stb),
      .l1_inc (l1_inc),
      .l2_inc (l2_inc)
   );

   wrev_accum #(.CNT_W(CNT_W), .INC_W(L1_INC_W)) u_acc_l1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cnt_en),
      .clr     (cnt_clr),
      .inc     (l1_inc),
      .count   (l1_wr_count),
      .wrapped (l1_wrap)
   );

   wrev_accum #(.CNT_W(CNT_W), .INC_W(L2_INC_W)) u_acc_l2 (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cnt_en),
      .clr     (cnt_clr),
      .inc     (l2_inc),
      .count   (l2_wr_count),
      .wrapped (l2_wrap)
   );

endmodule

// File: rtl/wrev_counters_chk.sv
module wrev_counters_chk #(
   parameter int unsigned CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             cnt_clr,
   input logic             l1_st_lookup,
   input logic             dc_zero_op,
   input logic             l2_cpu_wr,
   input logic             l2_wr_hit,
   input logic             l1d_evict,
   input logic             l1d_evict_dirty,
   input logic             l1i_evict,
   input logic             stream_wr,
   input logic             ext_snoop,
   input logic [CNT_W-1:0] l1_wr_count,
   input logic [CNT_W-1:0] l2_wr_count,
   input logic             l1_wrap,
   input logic             l2_wrap
);

   logic run;
   logic no_l2_src;
   assign run       = cnt_en && !cnt_clr;
   assign no_l2_src = !l2_cpu_wr && !l1d_evict && !l1i_evict && !stream_wr && !dc_zero_op;

   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (l1_wr_count == '0) && (l2_wr_count == '0) && !l1_wrap && !l2_wrap);

   p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !cnt_clr) |=> $stable(l1_wr_count) && $stable(l2_wr_count)
                                && $stable(l1_wrap) && $stable(l2_wrap));

   p_store_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && l1_st_lookup && !dc_zero_op)
         |=> l1_wr_count == CNT_W'($past(l1_wr_count) + 1'b1));

   p_cpu_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && l2_cpu_wr && !l2_wr_hit && !l1d_evict && !l1i_evict && !stream_wr && !dc_zero_op)
         |=> l2_wr_count == CNT_W'($past(l2_wr_count) + 1'b1));

   p_dirty_evict_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && l1d_evict && l1d_evict_dirty && !l2_cpu_wr && !l1i_evict && !stream_wr && !dc_zero_op)
         |=> l2_wr_count == CNT_W'($past(l2_wr_count) + 1'b1));

   p_stream_l1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && stream_wr && !l1_st_lookup && !dc_zero_op) |=> $stable(l1_wr_count));

   p_snoop_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ext_snoop && no_l2_src && !l1_st_lookup)
         |=> $stable(l1_wr_count) && $stable(l2_wr_count));

   p_wrap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_wrap && !cnt_clr) |=> l1_wrap);

endmodule

bind wrev_counters wrev_counters_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_wrev_counters.sv
`timescale 1ns/1ps
module sim_wrev_counters;

   localparam int unsigned SW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_en = 1'b0, cnt_clr = 1'b0;
   logic l1_st_lookup = 1'b0, dc_zero_op = 1'b0, l2_cpu_wr = 1'b0, l2_wr_hit = 1'b0;
   logic l1d_evict = 1'b0, l1d_evict_dirty = 1'b0, l1i_evict = 1'b0, stream_wr = 1'b0;
   logic ext_snoop = 1'b0;

   logic [63:0]   c1, c2;
   logic          w1, w2;
   logic [SW-1:0] s1, s2;
   logic          sw1, sw2;

   // reference model
   logic [63:0]   m1, m2;
   logic          mw1, mw2;
   logic [SW-1:0] ms1, ms2;
   logic          msw1, msw2;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   wrev_counters u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
      .l1_st_lookup(l1_st_lookup), .dc_zero_op(dc_zero_op), .l2_cpu_wr(l2_cpu_wr),
      .l2_wr_hit(l2_wr_hit), .l1d_evict(l1d_evict), .l1d_evict_dirty(l1d_evict_dirty),
      .l1i_evict(l1i_evict), .stream_wr(stream_wr), .ext_snoop(ext_snoop),
      .l1_wr_count(c1), .l2_wr_count(c2), .l1_wrap(w1), .l2_wrap(w2));

   wrev_counters #(.CNT_W(SW)) u1 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
      .l1_st_lookup(l1_st_lookup), .dc_zero_op(dc_zero_op), .l2_cpu_wr(l2_cpu_wr),
      .l2_wr_hit(l2_wr_hit), .l1d_evict(l1d_evict), .l1d_evict_dirty(l1d_evict_dirty),
      .l1i_evict(l1i_evict), .stream_wr(stream_wr), .ext_snoop(ext_snoop),
      .l1_wr_count(s1), .l2_wr_count(s2), .l1_wrap(sw1), .l2_wrap(sw2));

   function automatic int l1_amt(logic [5:0] s);
      return int'(s[0]) + int'(s[1]);
   endfunction

   function automatic int l2_amt(logic [5:0] s);
      return int'(s[1]) + int'(s[2]) + int'(s[3]) + int'(s[4]) + int'(s[5]);
   endfunction

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "l1 count", c1, m1);
      chk(tag, "l2 count", c2, m2);
      chk(tag, "l1 wrap", {63'd0, w1}, {63'd0, mw1});
      chk(tag, "l2 wrap", {63'd0, w2}, {63'd0, mw2});
      chk(tag, "narrow l1 count", {58'd0, s1}, {58'd0, ms1});
      chk(tag, "narrow l2 count", {58'd0, s2}, {58'd0, ms2});
      chk(tag, "narrow l1 wrap", {63'd0, sw1}, {63'd0, msw1});
      chk(tag, "narrow l2 wrap", {63'd0, sw2}, {63'd0, msw2});
   endtask

   // s bits: 0 store lookup, 1 zero op, 2 cpu write, 3 data evict, 4 instr evict, 5 stream
   task automatic cyc(input logic en, input logic clr, input logic [5:0] s,
                      input logic hit, input logic dirty, input logic snp, input string tag);
      logic [64:0]   t;
      logic [SW:0]   u;
      @(negedge clk);
      cnt_en = en; cnt_clr = clr;
      l1_st_lookup = s[0]; dc_zero_op = s[1]; l2_cpu_wr = s[2];
      l1d_evict = s[3]; l1i_evict = s[4]; stream_wr = s[5];
      l2_wr_hit = hit; l1d_evict_dirty = dirty; ext_snoop = snp;
      @(posedge clk);
      if (clr) begin
         m1 = '0; m2 = '0; mw1 = 0; mw2 = 0;
         ms1 = '0; ms2 = '0; msw1 = 0; msw2 = 0;
      end else if (en) begin
         t = {1'b0, m1} + 65'(l1_amt(s)); m1 = t[63:0]; if (t[64]) mw1 = 1;
         t = {1'b0, m2} + 65'(l2_amt(s)); m2 = t[63:0]; if (t[64]) mw2 = 1;
         u = {1'b0, ms1} + (SW+1)'(l1_amt(s)); ms1 = u[SW-1:0]; if (u[SW]) msw1 = 1;
         u = {1'b0, ms2} + (SW+1)'(l2_amt(s)); ms2 = u[SW-1:0]; if (u[SW]) msw2 = 1;
      end
      #1;
      compare_all(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      m1 = '0; m2 = '0; mw1 = 0; mw2 = 0;
      ms1 = '0; ms2 = '0; msw1 = 0; msw2 = 0;
      repeat (3) @(posedge clk);
      #1 compare_all("R1");
      @(negedge clk) rst_n = 1'b1;
      #1 compare_all("R1");

      cyc(1, 0, 6'b000001, 0, 0, 0, "R2");
      cyc(1, 0, 6'b000010, 0, 0, 0, "R3");
      cyc(1, 0, 6'b000100, 1, 0, 0, "R4");
      cyc(1, 0, 6'b000100, 0, 0, 0, "R4");
      cyc(1, 0, 6'b001000, 0, 0, 0, "R5");
      cyc(1, 0, 6'b001000, 0, 1, 0, "R5");
      cyc(1, 0, 6'b010000, 0, 0, 0, "R5");
      cyc(1, 0, 6'b100000, 0, 0, 0, "R6");
      cyc(1, 0, 6'b000000, 0, 0, 1, "R7");
      cyc(1, 0, 6'b111111, 1, 1, 1, "R8");
      cyc(1, 0, 6'b111110, 0, 0, 0, "R8");
      cyc(0, 0, 6'b111111, 0, 0, 1, "R11");
      cyc(0, 0, 6'b000001, 0, 0, 0, "R11");
      cyc(1, 1, 6'b111111, 0, 0, 0, "R9");
      cyc(0, 1, 6'b000000, 0, 0, 0, "R9");

      // fill the narrow instance past its range
      for (int i = 0; i < 15; i++) cyc(1, 0, 6'b111111, 0, 0, 0, "R10");
      cyc(1, 0, 6'b000000, 0, 0, 1, "R10");
      for (int i = 0; i < 30; i++) cyc(1, 0, 6'b000011, 0, 0, 0, "R10");
      cyc(0, 0, 6'b111111, 0, 0, 0, "R10");
      cyc(1, 1, 6'b000000, 0, 0, 0, "R9");

      for (int i = 0; i < 3000; i++) begin
         logic [5:0] s;
         s = 6'($urandom);
         cyc(($urandom % 8) != 0, ($urandom % 97) == 0, s,
             1'($urandom), 1'($urandom), 1'($urandom), "R8");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule